// File: doc/BRIEF.md
# I2C Target Interface with Address Recognition

This block is the target (slave) side of an I2C bus. It brings SCL and SDA into the system clock domain through a short flip-flop chain and finds their edges there. From those edges it recognises START and STOP conditions and shifts bits in and out. The first byte after every START is compared against a programmable 8-bit address register. Bits [7:1] of that register hold the 7-bit target address. Bit [0] enables answering the general call (all-zero) address. The first byte of a 10-bit address is matched by the same compare, with the register set to `11110` followed by address bits 9:8. A promiscuous option accepts every address and ignores the register.

After each recognised address byte and after each data byte the block holds SCL low. A host-side register interface then inspects the status flags (address/stop event, data event, event source, transfer direction, clock hold) and moves one byte through the single data register. A release pulse, or a read of the data register when smart mode is enabled, lets the bus continue. The release also applies the chosen acknowledge action. In a read transfer, the master's ACK after each byte sent makes the block hold the clock again for the next byte. A NACK ends the data phase.

Top module: `i2c_tgt_addr`

## Requirements
- R1: After reset the address and data registers read 0x00, all status flags are 0, and neither SCL nor SDA is pulled low.
- R2: An address byte whose bits [7:1] equal address register bits [7:1] (and are not all zero) is recognised. The address/stop flag rises, the source flag reads 1 (address), SCL is held low, and after a release with the acknowledge action set to 0 the target pulls SDA low in the ninth clock.
- R3: A byte that is not recognised raises no flag, is not acknowledged (SDA stays high in the ninth clock), leaves SCL free, and the target ignores the bus until the next START.
- R4: The general call byte (bits [7:1] all zero) is recognised only when address register bit 0 is 1.
- R5: A 10-bit first byte `11110nnR` is recognised when the address register bits [7:1] are `11110nn`. The next byte of that write transfer is delivered to the host as ordinary data, with the data flag set and no address compare.
- R6: In promiscuous mode every address byte is recognised, whatever the address register holds.
- R7: On recognition the direction flag takes bit 0 of the address byte (1 = master reads).
- R8: In a master-write transfer, after eight data bits the data flag is set, SCL is held low and the data register holds the received byte, MSB first on the bus.
- R9: The acknowledge action input selects ACK (0) or NACK (1) at each release in a write transfer. After a NACK, later bytes raise no flag and cause no hold until the next START.
- R10: In a master-read transfer the target holds SCL after its address ACK and after each byte the master ACKs, with the data flag set. On release it shifts the data register out MSB first. A master NACK leaves SCL free and ends the data phase.
- R11: Writes to the data register while SCL is not held have no effect.
- R12: With smart mode on, a host read of the data register during a hold performs the release with the selected acknowledge action. With smart mode off, the same read leaves the hold in place.
- R13: A STOP after the target was addressed sets the address/stop flag with the source flag at 0 and holds no clock. A repeated START in the middle of a byte returns the block to the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_promisc | input | 1 | Accept every address |
| cfg_smart | input | 1 | Data-register read performs the release |
| cfg_ackact | input | 1 | Acknowledge action on release: 0 ACK, 1 NACK |
| addr_we | input | 1 | Write strobe for the address register |
| addr_wdata | input | 8 | Address register write value |
| addr_q | output | 8 | Address register contents |
| data_we | input | 1 | Write strobe for the data register (honoured only during a hold) |
| data_wdata | input | 8 | Data register write value |
| data_re | input | 1 | Host read strobe of the data register |
| data_q | output | 8 | Data register contents |
| resp_go | input | 1 | Release pulse: apply acknowledge action and free SCL |
| flag_apif | output | 1 | Address-or-stop event flag |
| flag_ap | output | 1 | Source of last address/stop event: 1 address, 0 STOP |
| flag_dif | output | 1 | Data event flag |
| flag_dir | output | 1 | Transfer direction, 1 = master reads |
| flag_hold | output | 1 | Target is holding SCL low |

## Verification
The bench walks address bytes past several register settings. These include an exact hit, a miss by one bit, the general call with its enable on and off, a 10-bit first byte, and promiscuous mode. A wrong compare shows up as a missing hold or a wrong ninth-clock level. Directed transfers cover the corners. A NACK that fails to end the write phase would raise a data flag on the following byte. Bits shifted in the wrong order would return a reversed byte to the master. A data-register write that slips through outside a hold would change the read-back value. A repeated START that is not honoured mid-byte would leave the second address byte unrecognised. A smart-mode release that also fires with smart mode off would drop the hold too early.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AHOLD,
      ST_ACK9,
      ST_RX,
      ST_RHOLD,
      ST_TX,
      ST_RACK,
      ST_THOLD
   } tgt_state_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES-1:0] pipe;
   logic              prev;

   // idle bus lines sit high, so the chain resets to 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '1;
         prev <= 1'b1;
      end else begin
         pipe <= {pipe[STAGES-2:0], line_i};
         prev <= pipe[STAGES-1];
      end
   end

   assign level_o = pipe[STAGES-1];
   assign rise_o  = pipe[STAGES-1] & ~prev;
   assign fall_o  = ~pipe[STAGES-1] & prev;

endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match #(
   parameter int W             = 8,
   parameter bit GCALL_SUPPORT = 1'b1
) (
   input  logic [W-1:0] rx_byte,
   input  logic [W-1:0] addr_cfg,
   input  logic         promisc,
   output logic         hit
);

   logic exact;
   logic gcall;

   // a zero address is reserved for the general call and never matches exactly
   assign exact = (rx_byte[W-1:1] == addr_cfg[W-1:1]) && (|rx_byte[W-1:1]);

   generate
      if (GCALL_SUPPORT) begin : g_gcall
         assign gcall = addr_cfg[0] && (rx_byte[W-1:1] == '0);
      end else begin : g_no_gcall
         assign gcall = 1'b0;
      end
   endgenerate

   assign hit = promisc | exact | gcall;

endmodule

// File: rtl/i2c_tgt_addr.sv
module i2c_tgt_addr
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter bit GCALL_SUPPORT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   output logic        scl_oe,
   output logic        sda_oe,
   input  logic        cfg_promisc,
   input  logic        cfg_smart,
   input  logic        cfg_ackact,
   input  logic        addr_we,
   input  logic [7:0]  addr_wdata,
   output logic [7:0]  addr_q,
   input  logic        data_we,
   input  logic [7:0]  data_wdata,
   input  logic        data_re,
   output logic [7:0]  data_q,
   input  logic        resp_go,
   output logic        flag_apif,
   output logic        flag_ap,
   output logic        flag_dif,
   output logic        flag_dir,
   output logic        flag_hold
);

   localparam int NLINES = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_tgt_addr: SYNC_STAGES must be at least 2");
      end
      if (BYTE_W != 8) begin : g_bad_width
         $error("i2c_tgt_addr: byte width must be 8");
      end
   endgenerate

   // index 0 = SCL, index 1 = SDA
   logic [NLINES-1:0] line_in, line_lvl, line_rise, line_fall;
   assign line_in = {sda_i, scl_i};

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_sync
         i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (line_in[i]),
            .level_o (line_lvl[i]),
            .rise_o  (line_rise[i]),
            .fall_o  (line_fall[i])
         );
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall;
   assign scl_s    = line_lvl[0];
   assign sda_s    = line_lvl[1];
   assign scl_rise = line_rise[0];
   assign scl_fall = line_fall[0];

   logic start_ev, stop_ev;
   assign start_ev = line_fall[1] & scl_s;
   assign stop_ev  = line_rise[1] & scl_s;

   tgt_state_t        state;
   logic [BYTE_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              ack_given;
   logic              from_addr;
   logic              active;
   logic              m_ack;
   logic              hit;
   logic              hold;
   logic              rel;
   logic              byte_done;

   i2c_tgt_match #(.W(BYTE_W), .GCALL_SUPPORT(GCALL_SUPPORT)) u_match (
      .rx_byte  (shreg),
      .addr_cfg (addr_q),
      .promisc  (cfg_promisc),
      .hit      (hit)
   );

   assign hold      = (state == ST_AHOLD) || (state == ST_RHOLD) || (state == ST_THOLD);
   assign rel       = hold && (resp_go || (cfg_smart && data_re));
   assign byte_done = scl_fall && (cnt == CNT_W'(BYTE_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (addr_we) begin
         addr_q <= addr_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         cnt       <= '0;
         sda_oe    <= 1'b0;
         ack_given <= 1'b0;
         from_addr <= 1'b0;
         active    <= 1'b0;
         m_ack     <= 1'b0;
         flag_apif <= 1'b0;
         flag_ap   <= 1'b0;
         flag_dif  <= 1'b0;
         flag_dir  <= 1'b0;
         data_q    <= '0;
      end else begin
         if (start_ev) begin
            state     <= ST_ADDR;
            cnt       <= '0;
            sda_oe    <= 1'b0;
            flag_apif <= 1'b0;
            flag_dif  <= 1'b0;
         end else if (stop_ev) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            if (active) begin
               flag_apif <= 1'b1;
               flag_ap   <= 1'b0;
            end
            active <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (byte_done) begin
                     if (hit) begin
                        state     <= ST_AHOLD;
                        flag_apif <= 1'b1;
                        flag_ap   <= 1'b1;
                        flag_dir  <= shreg[0];
                        active    <= 1'b1;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_AHOLD, ST_RHOLD: begin
                  if (rel) begin
                     flag_apif <= 1'b0;
                     flag_dif  <= 1'b0;
                     sda_oe    <= ~cfg_ackact;
                     ack_given <= ~cfg_ackact;
                     from_addr <= (state == ST_AHOLD);
                     state     <= ST_ACK9;
                  end
               end
               ST_ACK9: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     if (!ack_given) begin
                        state <= ST_IDLE;
                     end else if (from_addr && flag_dir) begin
                        state    <= ST_THOLD;
                        flag_dif <= 1'b1;
                     end else begin
                        state <= ST_RX;
                     end
                  end
               end
               ST_RX: begin
                  if (scl_rise) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (byte_done) begin
                     state    <= ST_RHOLD;
                     flag_dif <= 1'b1;
                     data_q   <= shreg;
                  end
               end
               ST_THOLD: begin
                  if (rel) begin
                     flag_apif <= 1'b0;
                     flag_dif  <= 1'b0;
                     shreg     <= data_q;
                     sda_oe    <= ~data_q[BYTE_W-1];
                     cnt       <= '0;
                     state     <= ST_TX;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (byte_done) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RACK;
                  end else if (scl_fall) begin
                     shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~shreg[BYTE_W-2];
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     m_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (m_ack) begin
                        state    <= ST_THOLD;
                        flag_dif <= 1'b1;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
         // host access to the data register only while the clock is held
         if (data_we && hold) begin
            data_q <= data_wdata;
         end
      end
   end

   assign scl_oe    = hold;
   assign flag_hold = hold;

endmodule

// File: rtl/i2c_tgt_addr_chk.sv
module i2c_tgt_addr_chk
   import i2c_tgt_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       flag_apif,
   input logic       flag_ap,
   input logic       flag_dif,
   input logic       flag_hold,
   input logic       sda_oe,
   input logic [7:0] data_q,
   input tgt_state_t state
);

   AST_ADDR_EVENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag_apif) && flag_ap) |-> flag_hold)
      else $error("address event without clock hold"); // R2

   AST_STOP_EVENT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag_apif) && !flag_ap) |-> !flag_hold)
      else $error("stop event while holding clock"); // R13

   AST_DATA_EVENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_dif) |-> flag_hold)
      else $error("data event without clock hold"); // R8

   AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_hold && !$past(flag_hold)) |-> $stable(data_q))
      else $error("data register changed outside a hold"); // R11

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe)
      else $error("SDA pulled while idle"); // R3

endmodule

bind i2c_tgt_addr i2c_tgt_addr_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flag_apif (flag_apif),
   .flag_ap   (flag_ap),
   .flag_dif  (flag_dif),
   .flag_hold (flag_hold),
   .sda_oe    (sda_oe),
   .data_q    (data_q),
   .state     (state)
);

// File: tb/i2c_tgt_addr_bench.sv
module i2c_tgt_addr_bench;

   localparam int Q  = 10;
   localparam int NV = 9;
   // {promisc, addr_reg, addr_byte, expect_match, ackact}
   localparam logic [18:0] VEC [NV] = '{
      {1'b0, 8'hA0, 8'hA0, 1'b1, 1'b0},
      {1'b0, 8'hA0, 8'hA1, 1'b1, 1'b1},
      {1'b0, 8'hA0, 8'hA2, 1'b0, 1'b0},
      {1'b0, 8'hA1, 8'h00, 1'b1, 1'b0},
      {1'b0, 8'hA0, 8'h00, 1'b0, 1'b0},
      {1'b0, 8'hF4, 8'hF4, 1'b1, 1'b0},
      {1'b0, 8'hF4, 8'hF6, 1'b0, 1'b0},
      {1'b1, 8'hA0, 8'h3C, 1'b1, 1'b0},
      {1'b1, 8'h00, 8'h11, 1'b1, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
   logic scl_oe, sda_oe, bus_scl, bus_sda;
   assign bus_scl = ~(m_scl_lo | scl_oe);
   assign bus_sda = ~(m_sda_lo | sda_oe);

   logic       cfg_promisc = 0, cfg_smart = 0, cfg_ackact = 0;
   logic       addr_we = 0, data_we = 0, data_re = 0, resp_go = 0;
   logic [7:0] addr_wdata = 0, data_wdata = 0, addr_q, data_q;
   logic       flag_apif, flag_ap, flag_dif, flag_dir, flag_hold;

   int checks = 0, errors = 0;

   i2c_tgt_addr u_i2c_tgt_addr (
      .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
      .scl_oe(scl_oe), .sda_oe(sda_oe),
      .cfg_promisc(cfg_promisc), .cfg_smart(cfg_smart), .cfg_ackact(cfg_ackact),
      .addr_we(addr_we), .addr_wdata(addr_wdata), .addr_q(addr_q),
      .data_we(data_we), .data_wdata(data_wdata), .data_re(data_re), .data_q(data_q),
      .resp_go(resp_go),
      .flag_apif(flag_apif), .flag_ap(flag_ap), .flag_dif(flag_dif),
      .flag_dir(flag_dir), .flag_hold(flag_hold)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic qwait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_scl_high;
      while (!bus_scl) @(negedge clk);
   endtask

   task automatic m_start;
      m_sda_lo = 0; qwait(Q);
      m_scl_lo = 0; wait_scl_high(); qwait(Q);
      m_sda_lo = 1; qwait(Q);
      m_scl_lo = 1; qwait(Q);
   endtask

   task automatic m_stop;
      m_sda_lo = 1; qwait(Q);
      m_scl_lo = 0; wait_scl_high(); qwait(Q);
      m_sda_lo = 0; qwait(Q);
   endtask

   task automatic m_bit_out(input logic b);
      m_sda_lo = ~b; qwait(Q);
      m_scl_lo = 0; wait_scl_high(); qwait(2*Q);
      m_scl_lo = 1; qwait(Q);
   endtask

   task automatic m_bit_in(output logic b);
      m_sda_lo = 0; qwait(Q);
      m_scl_lo = 0; wait_scl_high(); qwait(Q);
      b = bus_sda; qwait(Q);
      m_scl_lo = 1; qwait(Q);
   endtask

   task automatic m_byte_out(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
   endtask

   task automatic m_byte_in(output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         m_bit_in(b);
         v[i] = b;
      end
   endtask

   task automatic host_addr(input logic [7:0] v);
      @(negedge clk); addr_we = 1; addr_wdata = v;
      @(negedge clk); addr_we = 0;
   endtask

   task automatic host_data(input logic [7:0] v);
      @(negedge clk); data_we = 1; data_wdata = v;
      @(negedge clk); data_we = 0;
   endtask

   task automatic host_release(input logic act);
      @(negedge clk); cfg_ackact = act; resp_go = 1;
      @(negedge clk); resp_go = 0;
   endtask

   task automatic host_read;
      @(negedge clk); data_re = 1;
      @(negedge clk); data_re = 0;
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic       b;
      logic [7:0] rb;
      qwait(5);
      // R1 reset state (sampled while reset is still active)
      chk_eq("R1 addr", addr_q, 0);
      chk_eq("R1 data", data_q, 0);
      chk_eq("R1 flags", {flag_apif, flag_ap, flag_dif, flag_dir, flag_hold}, 0);
      chk_eq("R1 drive", {scl_oe, sda_oe}, 0);
      rst_n = 1; qwait(5);

      // address table walk
      for (int v = 0; v < NV; v++) begin
         logic       pm, mt, aa;
         logic [7:0] ar, ab;
         string      tag;
         {pm, ar, ab, mt, aa} = VEC[v];
         if (pm)                tag = "R6";
         else if (ab[7:1] == 0) tag = "R4";
         else if (ar[7:3] == 5'b11110) tag = "R5";
         else if (mt)           tag = "R2";
         else                   tag = "R3";
         cfg_promisc = pm;
         host_addr(ar);
         m_start();
         m_byte_out(ab);
         chk_eq({tag, " hold"}, flag_hold, mt);
         chk_eq({tag, " apif"}, flag_apif, mt);
         if (mt) begin
            chk_eq({tag, " ap"}, flag_ap, 1);
            chk_eq("R7 dir", flag_dir, ab[0]);
            host_release(aa);
         end
         m_bit_in(b);
         chk_eq({tag, " ninth"}, b, (mt && !aa) ? 0 : 1);
         m_stop();
         chk_eq("R13 stop apif", flag_apif, mt);
         if (mt) chk_eq("R13 stop ap", flag_ap, 0);
      end
      cfg_promisc = 0;

      // write transfer with ACK, then NACK, then ignored byte
      host_addr(8'hA0);
      m_start(); m_byte_out(8'hA0); host_release(0); m_bit_in(b);
      chk_eq("R2 ack", b, 0);
      m_byte_out(8'h5A);
      chk_eq("R8 dif", flag_dif, 1);
      chk_eq("R8 hold", flag_hold, 1);
      chk_eq("R8 data", data_q, 8'h5A);
      host_release(0); m_bit_in(b);
      chk_eq("R9 ack", b, 0);
      m_byte_out(8'hC3);
      chk_eq("R8 data2", data_q, 8'hC3);
      host_release(1); m_bit_in(b);
      chk_eq("R9 nack", b, 1);
      m_byte_out(8'hFF);
      chk_eq("R9 ignored dif", flag_dif, 0);
      chk_eq("R9 ignored hold", flag_hold, 0);
      chk_eq("R9 ignored data", data_q, 8'hC3);
      m_bit_in(b);
      chk_eq("R9 ignored ack", b, 1);
      // R11 write outside a hold
      host_data(8'h77);
      qwait(2);
      chk_eq("R11 data", data_q, 8'hC3);
      m_stop();
      chk_eq("R13 apif", flag_apif, 1);
      chk_eq("R13 ap", flag_ap, 0);
      chk_eq("R13 hold", flag_hold, 0);

      // 10-bit first byte then second byte as data
      host_addr(8'hF4);
      m_start(); m_byte_out(8'hF4);
      chk_eq("R5 hold", flag_hold, 1);
      host_release(0); m_bit_in(b);
      m_byte_out(8'h33);
      chk_eq("R5 dif", flag_dif, 1);
      chk_eq("R5 data", data_q, 8'h33);
      host_release(0); m_bit_in(b);
      m_stop();

      // read transfer
      host_addr(8'hA0);
      m_start(); m_byte_out(8'hA1);
      chk_eq("R7 dir read", flag_dir, 1);
      host_release(0); m_bit_in(b);
      chk_eq("R10 addr ack", b, 0);
      chk_eq("R10 hold", flag_hold, 1);
      chk_eq("R10 dif", flag_dif, 1);
      host_data(8'h96);
      chk_eq("R10 data write", data_q, 8'h96);
      host_release(0);
      m_byte_in(rb);
      chk_eq("R10 byte1", rb, 8'h96);
      m_bit_out(0);
      chk_eq("R10 hold2", flag_hold, 1);
      chk_eq("R10 dif2", flag_dif, 1);
      host_data(8'h3B); host_release(0);
      m_byte_in(rb);
      chk_eq("R10 byte2", rb, 8'h3B);
      m_bit_out(1);
      chk_eq("R10 nack free", flag_hold, 0);
      m_stop();

      // smart mode
      m_start(); m_byte_out(8'hA0); host_release(0); m_bit_in(b);
      m_byte_out(8'h11);
      cfg_smart = 0; host_read(); qwait(3);
      chk_eq("R12 no smart hold", flag_hold, 1);
      cfg_smart = 1; cfg_ackact = 1; host_read(); qwait(3);
      chk_eq("R12 smart release", flag_hold, 0);
      m_bit_in(b);
      chk_eq("R12 smart nack", b, 1);
      cfg_smart = 0;
      m_stop();

      // repeated START in the middle of a data byte
      m_start(); m_byte_out(8'hA0); host_release(0); m_bit_in(b);
      for (int i = 0; i < 4; i++) m_bit_out(1'b1);
      m_start();
      m_byte_out(8'hA0);
      chk_eq("R13 rstart hold", flag_hold, 1);
      chk_eq("R13 rstart ap", {flag_apif, flag_ap}, 2'b11);
      host_release(0); m_bit_in(b);
      chk_eq("R13 rstart ack", b, 0);
      m_stop();

      finish_run();
   end

endmodule